// File: doc/BRIEF.md
# Pipelined Wide Accumulator

This block is a 24-bit running accumulator for a noise-shaping modulator that must run at a high clock rate. The carry path is cut into three 8-bit slices. Each slice uses a carry-lookahead adder and holds its own part of the running sum in a register. Each slice passes its carry to the next slice through a register. The upper slices therefore work on their share of an addend one and two clocks after the lowest slice does. The addend and load inputs are delayed for each slice to match that timing. The slice sums are then delayed again by different amounts, so that all 24 result bits and the wrap carry appear together.

A new addend is accepted on every clock and the block never stalls. A synchronous load replaces the running value with a seed, for example a non-zero start value that breaks up limit cycles. The load passes through the slices with the same timing as an addend. Seen from outside, the block behaves exactly like a plain 24-bit modular accumulator whose outputs are delayed by three cycles.

Top module: `pipe_accum`

## Requirements
- R1: While `rst_ni` is low, and on every cycle until the first addend has passed through, `sum_o` reads 0 and `carry_o` reads 0.
- R2: The value of `addend_i` sampled at the clock edge that ends cycle n is added to the running value modulo 2^24. The new value is shown on `sum_o` during cycle n+3.
- R3: `carry_o` during cycle n+3 is 1 exactly when the addition for cycle n went past 2^24-1, and it is 0 otherwise.
- R4: One addend is accepted per clock with no idle cycles. A long run of back-to-back addends gives the same results as the unpipelined accumulator.
- R5: When `load_i` is 1 in cycle n, the running value becomes `seed_i` and the `addend_i` of that cycle is ignored. During cycle n+3, `sum_o` equals the seed and `carry_o` is 0.
- R6: Carries that cross bit 7→8 and bit 15→16 are added correctly, including an increment that ripples through all three slices at once (0xFFFFFF+1 gives 0 with `carry_o`=1).
- R7: Addends in the cycles right after a load accumulate onto the seed. Addends in the cycles right before a load show their results up to the cycle before the seed appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Replace the running value with seed_i |
| seed_i | input | 24 | Value written by a load |
| addend_i | input | 24 | Value added each cycle (ignored during a load) |
| sum_o | output | 24 | Running value, aligned across slices |
| carry_o | output | 1 | Wrap carry of the step shown on sum_o |

## Verification
A load can enter the lowest slice while the two addends before it are still moving through the middle and top slices. The carry from the last addend before the load therefore reaches an upper slice in the same cycle that the load reaches it. The bench sets this up by seeding just below a slice boundary, streaming increments, and then loading in the middle of the stream with a non-zero addend. It also loads while carries cross every boundary during a long random run. Every aligned output is compared with an unpipelined accumulator delayed by three cycles. A wrong ordering between the carry and the load, or a wrong skew depth, shows up as a mismatch of sum or carry.

// File: rtl/pipe_accum_pkg.sv
package pipe_accum_pkg;
  parameter int unsigned SLICE_W    = 8;
  parameter int unsigned NUM_SLICES = 3;
  localparam int unsigned ACC_W     = SLICE_W * NUM_SLICES;
endpackage

// File: rtl/pa_cla_adder.sv
module pa_cla_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] gen, prop;
  logic [W:0]   cy;

  assign gen  = a_i & b_i;
  assign prop = a_i ^ b_i;

  // flat lookahead: each carry from generate/propagate terms, no ripple
  always_comb begin
    logic term, pchain;
    cy[0] = cin_i;
    for (int i = 0; i < W; i++) begin
      term   = gen[i];
      pchain = prop[i];
      for (int j = i - 1; j >= 0; j--) begin
        term   = term | (pchain & gen[j]);
        pchain = pchain & prop[j];
      end
      cy[i+1] = term | (pchain & cin_i);
    end
  end

  assign sum_o  = prop ^ cy[W-1:0];
  assign cout_o = cy[W];
endmodule

// File: rtl/pa_delay_line.sv
module pa_delay_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] stage_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
      end else begin
        stage_q[0] <= d_i;
        for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
      end
    end
    assign q_o = stage_q[DEPTH-1];
  end
endmodule

// File: rtl/pa_slice.sv
module pa_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic [W-1:0] add_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] acc_q, acc_d;
  logic         cy_q, cy_d;

  pa_cla_adder #(.W(W)) u_cla (
    .a_i   (acc_q),
    .b_i   (add_i),
    .cin_i (cin_i),
    .sum_o (acc_d),
    .cout_o(cy_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (load_i) begin
      acc_q <= seed_i;
      cy_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
    end
  end

  assign sum_o  = acc_q;
  assign cout_o = cy_q;

  a_r5_slice_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sum_o == $past(seed_i) && !cout_o));

  a_r2_slice_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ({cout_o, sum_o} ==
      ({1'b0, $past(sum_o)} + {1'b0, $past(add_i)} + (W+1)'($past(cin_i)))));
endmodule

// File: rtl/pipe_accum.sv
module pipe_accum
  import pipe_accum_pkg::*;
#(
  parameter int unsigned SW  = SLICE_W,
  parameter int unsigned NS  = NUM_SLICES,
  localparam int unsigned AW = SW * NS,
  localparam int unsigned PW = 2 * SW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] seed_i,
  input  logic [AW-1:0] addend_i,
  output logic [AW-1:0] sum_o,
  output logic          carry_o
);
  logic [SW-1:0] add_sk  [NS];
  logic [SW-1:0] seed_sk [NS];
  logic          load_sk [NS];
  logic [SW-1:0] part_q  [NS];
  logic          cy_q    [NS];

  for (genvar k = 0; k < NS; k++) begin : g_slice
    logic [PW-1:0] in_raw, in_dly;
    logic          cin;

    assign in_raw = {load_i, seed_i[k*SW +: SW], addend_i[k*SW +: SW]};

    // slice k runs k cycles behind slice 0
    pa_delay_line #(.W(PW), .DEPTH(k)) u_skew (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (in_raw),
      .q_o   (in_dly)
    );
    assign load_sk[k] = in_dly[PW-1];
    assign seed_sk[k] = in_dly[SW +: SW];
    assign add_sk[k]  = in_dly[SW-1:0];

    if (k == 0) begin : g_cin0
      assign cin = 1'b0;
    end else begin : g_cinn
      assign cin = cy_q[k-1];
    end

    pa_slice #(.W(SW)) u_slice (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load_sk[k]),
      .seed_i(seed_sk[k]),
      .add_i (add_sk[k]),
      .cin_i (cin),
      .sum_o (part_q[k]),
      .cout_o(cy_q[k])
    );

    // de-skew: lower slices wait for the top slice
    pa_delay_line #(.W(SW), .DEPTH(NS - 1 - k)) u_deskew (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (part_q[k]),
      .q_o   (sum_o[k*SW +: SW])
    );
  end

  assign carry_o = cy_q[NS-1];

  a_r3_carry_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (sum_o < $past(sum_o)));

  if (NS == 3) begin : g_chk3
    a_r5_load_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> ##2 (sum_o == $past(seed_i, 3) && !carry_o));
  end
endmodule

// File: tb/sim_pipe_accum.sv
module sim_pipe_accum;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [23:0] seed_i = '0;
  logic [23:0] addend_i = '0;
  logic [23:0] sum_o;
  logic        carry_o;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  logic [23:0] ref_s = '0;
  logic        ref_c = 1'b0;
  logic [23:0] h_s [3] = '{default: '0};
  logic        h_c [3] = '{default: 1'b0};

  always #5 clk_i = ~clk_i;

  pipe_accum u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .addend_i(addend_i),
    .sum_o   (sum_o),
    .carry_o (carry_o)
  );

  task automatic check(input string tag, input logic [23:0] es, input logic ec);
    n_chk++;
    if (sum_o !== es || carry_o !== ec) begin
      n_fail++;
      $display("FAIL %s: sum=%h carry=%b expected sum=%h carry=%b", tag, sum_o, carry_o, es, ec);
    end
  endtask

  // inputs driven while clk low; outputs checked at the following negedge
  task automatic step(input logic ld, input logic [23:0] sd, input logic [23:0] ad,
                      input string tag);
    load_i = ld; seed_i = sd; addend_i = ad;
    @(posedge clk_i);
    if (ld) begin
      ref_s = sd; ref_c = 1'b0;
    end else begin
      {ref_c, ref_s} = {1'b0, ref_s} + {1'b0, ad};
    end
    h_s[2] = h_s[1]; h_s[1] = h_s[0]; h_s[0] = ref_s;
    h_c[2] = h_c[1]; h_c[1] = h_c[0]; h_c[0] = ref_c;
    @(negedge clk_i);
    check(tag, h_s[2], h_c[2]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 24'h0, 1'b0);
    rst_ni = 1'b1;
    step(1'b0, 24'h0, 24'h0, "R1 after reset");
    step(1'b0, 24'h0, 24'h0, "R1 after reset");

    // R5 + R6: seed below low boundary, addend during load ignored
    step(1'b1, 24'h00FFFE, 24'h123456, "R5 load");
    for (int i = 0; i < 4; i++) step(1'b0, 24'h0, 24'h1, "R6 boundary 15/16");
    for (int i = 0; i < 3; i++) step(1'b0, 24'h0, 24'h0, "R5 flush");

    // R3 + R6: full-width ripple and wrap
    step(1'b1, 24'hFFFFFF, 24'h0, "R3 load top");
    step(1'b0, 24'h0, 24'h1, "R3 wrap");
    step(1'b0, 24'h0, 24'h0, "R3 no wrap");
    step(1'b0, 24'h0, 24'hFFFFFF, "R3 add max");
    step(1'b0, 24'h0, 24'hFFFFFF, "R3 add max wrap");
    for (int i = 0; i < 3; i++) step(1'b0, 24'h0, 24'h0, "R3 flush");

    // R6: sweep around each slice boundary
    for (int b = 1; b <= 3; b++) begin
      for (int k = 0; k < 16; k++) begin
        step(1'b1, 24'((32'h1 << (8 * b)) - 1 - k), 24'h0, "R6 seed");
        step(1'b0, 24'h0, 24'(k + 1), "R6 cross");
        step(1'b0, 24'h0, 24'(k), "R6 cross");
      end
    end
    for (int i = 0; i < 3; i++) step(1'b0, 24'h0, 24'h0, "R6 flush");

    // R7: load in the middle of a stream of increments crossing a boundary
    for (int r = 0; r < 8; r++) begin
      step(1'b1, 24'(24'h00FFFD + r * 24'h00FF00), 24'h0, "R7 seed");
      step(1'b0, 24'h0, 24'h1, "R7 before");
      step(1'b0, 24'h0, 24'h1, "R7 before");
      step(1'b1, 24'(24'hFFFFFE - r), 24'h00ABCD, "R7 load in stream");
      step(1'b0, 24'h0, 24'h1, "R7 after");
      step(1'b0, 24'h0, 24'h1, "R7 after");
      step(1'b0, 24'h0, 24'h3, "R7 after");
    end

    // R2 + R4: patterned sweep, back to back
    for (int i = 0; i < 1024; i++)
      step(1'b0, 24'h0, {8'(i), 8'(i * 7), 8'(i * 13)}, "R2 sweep");

    // R4 + R5: long random stream with occasional loads
    for (int i = 0; i < 3000; i++) begin
      logic ld;
      ld = ($urandom % 64) == 0;
      step(ld, 24'($urandom), 24'($urandom), ld ? "R5 random load" : "R4 random");
    end
    for (int i = 0; i < 3; i++) step(1'b0, 24'h0, 24'h0, "R2 flush");

    finish_run();
  end
endmodule